// File: doc/BRIEF.md
# Reference Output Mode Divider

This block derives a reference output from a reference input under a 3-bit mode code. It runs on the system clock. The reference input is a level sampled on every system clock edge, and the reference output is a registered signal synchronous to that clock.

The mode code sets one of four behaviours:
- The two lowest codes stand for the crystal path, either shut down or running.
- One code enables the input path and holds the output low.
- One code passes the input straight through, buffered.
- The four highest codes divide the input by 2, 4, 8 or 16. The divided output is taken from a binary counter of input rising edges, so it has no decoding glitches.

The oscillator and crystal circuitry lie outside the block. They appear only as two status outputs.

The mode is held in a register that a load strobe writes. Reset puts it in divide-by-eight. When a load changes the mode, the edge counter clears, so the new ratio starts from a clean phase.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high at a clock edge, the mode becomes code 6 (divide by 8), the edge counter and the sampled input clear, and `ref_out`, `osc_en` and `xtal_mode` read 0 after that edge.
- R2: A clock edge with `mode_load` high writes `mode_code` into the mode register. The new mode governs the outputs from the next cycle on. With `mode_load` low, the mode holds.
- R3: In codes 0 and 1, `ref_out` is 0 and `xtal_mode` is 1. `osc_en` is 1 in code 1 and 0 in code 0.
- R4: In code 2, `ref_out` is 0, and `osc_en` and `xtal_mode` are both 0.
- R5: In code 3, `ref_out` equals the value `ref_in` had at the previous clock edge.
- R6: In codes 4 to 7, `ref_out` is bit (code−4) of the 4-bit count of input rising edges since the last clear. This gives division by 2, 4, 8 and 16. The first high level appears after 1, 2, 4 or 8 rising edges. In these codes `osc_en` and `xtal_mode` are 0.
- R7: A rising edge is a clock edge at which `ref_in` is 1 and the value sampled at the previous edge was 0. Each rising edge adds exactly one to the counter, modulo 16, however long the input then stays high.
- R8: A load whose code differs from the current mode clears the counter at that edge. A rising edge in the same cycle is discarded.
- R9: A load of the code already in force leaves the counter running, and a rising edge in that cycle is counted.
- R10: Reset takes priority over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference input level, sampled each clock |
| mode_load | input | 1 | Writes `mode_code` into the mode register |
| mode_code | input | 3 | Mode code to be loaded |
| ref_out | output | 1 | Reference output |
| osc_en | output | 1 | Oscillator running status (code 1) |
| xtal_mode | output | 1 | Crystal path selected (codes 0 and 1) |

## Verification
Two events can fall in the same clock edge: a mode load and an input rising edge. In that cycle the clear and the increment compete for the counter. The bench forces this with directed cases that raise `ref_in` in the cycle a differing code is loaded, and again with a repeated code. Random stimulus with frequent loads then produces many more such coincidences. A reference model in the bench applies the rule that the clear discards the edge and a same-code load does not. The bench compares `ref_out` against that model every cycle, so any miscounted edge shows as a wrong phase later on.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int MODE_W = 3;
    localparam int CNT_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        M_XTAL_OFF = 3'd0,
        M_XTAL_ON  = 3'd1,
        M_REF_LOW  = 3'd2,
        M_REF_BUF  = 3'd3,
        M_DIV2     = 3'd4,
        M_DIV4     = 3'd5,
        M_DIV8     = 3'd6,
        M_DIV16    = 3'd7
    } ref_mode_e;

    localparam ref_mode_e MODE_RESET = M_DIV8;

    typedef struct packed {
        logic osc_en;
        logic xtal_mode;
    } osc_stat_t;

    function automatic logic is_divide(ref_mode_e m);
        return m >= M_DIV2;
    endfunction

    function automatic logic [1:0] tap_index(ref_mode_e m);
        logic [MODE_W-1:0] raw;
        raw = m;
        return raw[1:0];
    endfunction

    function automatic osc_stat_t status_of(ref_mode_e m);
        osc_stat_t s;
        s.osc_en    = (m == M_XTAL_ON);
        s.xtal_mode = (m == M_XTAL_ON) || (m == M_XTAL_OFF);
        return s;
    endfunction

endpackage

// File: rtl/refdiv_mode_reg.sv
module refdiv_mode_reg
    import refdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] code_in,
    output ref_mode_e         mode,
    output logic              restart
);

    // A differing code restarts the divider phase at the same edge.
    assign restart = load && (code_in != MODE_W'(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (load) begin
            mode <= ref_mode_e'(code_in);
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (MODE_W'(mode) == $past(code_in))) else $error("load"); // R2
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(rst)) |=> $stable(mode)) else $error("hold"); // R2

endmodule

// File: rtl/refdiv_edge_cnt.sv
module refdiv_edge_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             restart,
    output logic             ref_q,
    output logic [CNT_W-1:0] cnt
);

    logic rise;
    assign rise = ref_in && !ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (rise) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0)) else $error("clear"); // R8
    AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!restart && rise) |=> (cnt == CNT_W'($past(cnt) + 1'b1))) else $error("step"); // R7
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!restart && !rise) |=> $stable(cnt)) else $error("idle"); // R7

endmodule

// File: rtl/refdiv_out_sel.sv
module refdiv_out_sel
    import refdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  ref_mode_e        mode,
    input  logic             ref_q,
    input  logic [CNT_W-1:0] cnt,
    output logic             ref_out,
    output osc_stat_t        stat
);

    logic [CNT_W-1:0] taps;

    // One tap per counter stage; stage k divides by 2^(k+1).
    for (genvar k = 0; k < CNT_W; k++) begin : g_tap
        assign taps[k] = cnt[k];
    end

    always_comb begin
        stat = status_of(mode);
        if (is_divide(mode)) begin
            ref_out = taps[tap_index(mode)];
        end else if (mode == M_REF_BUF) begin
            ref_out = ref_q;
        end else begin
            ref_out = 1'b0;
        end
    end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_code,
    output logic              ref_out,
    output logic              osc_en,
    output logic              xtal_mode
);

    ref_mode_e        mode;
    logic             restart;
    logic             ref_q;
    logic [CNT_W-1:0] cnt;
    osc_stat_t        stat;

    refdiv_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .load    (mode_load),
        .code_in (mode_code),
        .mode    (mode),
        .restart (restart)
    );

    refdiv_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ref_in  (ref_in),
        .restart (restart),
        .ref_q   (ref_q),
        .cnt     (cnt)
    );

    refdiv_out_sel #(.CNT_W(CNT_W)) u_sel (
        .mode    (mode),
        .ref_q   (ref_q),
        .cnt     (cnt),
        .ref_out (ref_out),
        .stat    (stat)
    );

    assign osc_en    = stat.osc_en;
    assign xtal_mode = stat.xtal_mode;

    AST_QUIET_MODES: assert property (@(posedge clk) disable iff (rst)
        (mode <= M_REF_LOW) |-> !ref_out) else $error("quiet"); // R3
    AST_BUF_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (mode == M_REF_BUF && !mode_load) |=> (ref_out == $past(ref_in))) else $error("buf"); // R5
    AST_OSC_IMPLIES_XTAL: assert property (@(posedge clk) disable iff (rst)
        osc_en |-> xtal_mode) else $error("stat"); // R3

endmodule

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_code = 3'd0;
    logic       ref_out, osc_en, xtal_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [2:0] m_mode = 3'd6;
    logic [3:0] m_cnt = 4'd0;
    logic       m_refq = 1'b0;

    always #2.5 clk = ~clk;

    refdiv_top dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .mode_load(mode_load),
        .mode_code(mode_code), .ref_out(ref_out), .osc_en(osc_en),
        .xtal_mode(xtal_mode)
    );

    function automatic logic exp_out(logic [2:0] m, logic [3:0] c, logic q);
        if (m >= 3'd4) return c[m - 3'd4];
        if (m == 3'd3) return q;
        return 1'b0;
    endfunction

    function automatic string tag_of(logic [2:0] m);
        if (m <= 3'd1) return "R3";
        if (m == 3'd2) return "R4";
        if (m == 3'd3) return "R5";
        return "R6";
    endfunction

    task automatic check(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Inputs are applied at the falling edge; the model steps at the rising edge.
    task automatic step(logic r, logic ld, logic [2:0] code, logic rs, string tag);
        logic rise;
        string t;
        rst = rs; ref_in = r; mode_load = ld; mode_code = code;
        @(posedge clk);
        if (rs) begin
            m_mode = 3'd6; m_cnt = 4'd0; m_refq = 1'b0;
        end else begin
            rise = r && !m_refq;
            if (ld && code != m_mode) begin
                m_mode = code; m_cnt = 4'd0;
            end else if (rise) begin
                m_cnt = m_cnt + 4'd1;
            end
            m_refq = r;
        end
        @(negedge clk);
        t = (tag != "") ? tag : tag_of(m_mode);
        check(ref_out, exp_out(m_mode, m_cnt, m_refq), t, "ref_out");
        check(osc_en, m_mode == 3'd1, t, "osc_en");
        check(xtal_mode, m_mode <= 3'd1, t, "xtal_mode");
    endtask

    task automatic toggle_run(int n, string tag);
        for (int i = 0; i < n; i++) step(i[0], 1'b0, 3'd0, 1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'd0, 1'b1, "R1");
        toggle_run(40, "R6");                    // default divide by 8
        step(1'b0, 1'b1, 3'd3, 1'b0, "R2");
        for (int i = 0; i < 12; i++) step(1'(i % 3 == 0), 1'b0, 3'd0, 1'b0, "R5");
        step(1'b0, 1'b1, 3'd0, 1'b0, "R2");
        toggle_run(8, "R3");
        step(1'b0, 1'b1, 3'd1, 1'b0, "R3");
        toggle_run(8, "R3");
        step(1'b0, 1'b1, 3'd2, 1'b0, "R4");
        toggle_run(8, "R4");
        step(1'b0, 1'b1, 3'd4, 1'b0, "R2");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 3'd0, 1'b0, "R7");   // held high counts once
        toggle_run(7, "R6");
        step(1'b0, 1'b0, 3'd0, 1'b0, "R8");
        step(1'b1, 1'b1, 3'd5, 1'b0, "R8");      // differing load with rise: edge dropped
        toggle_run(10, "R8");
        step(1'b0, 1'b0, 3'd0, 1'b0, "R9");
        step(1'b1, 1'b1, 3'd5, 1'b0, "R9");      // same-code load with rise: edge counted
        toggle_run(10, "R9");
        step(1'b0, 1'b1, 3'd7, 1'b1, "R10");     // reset beats load
        toggle_run(36, "R10");
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rv;
            rv = $urandom();
            step(rv[0] ^ rv[1], rv[6:2] == 5'd0, rv[9:7], rv[19:10] == 10'd0, "");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(100000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule